// File: doc/BRIEF.md
# Energy-Detect Power State Controller

This block decides when an Ethernet PHY may power down its receive and transmit circuitry to save energy. It follows three states. In the normal state the PHY works as usual. In the low-power state most analog circuitry is off, and only the signal-energy detector stays active. In the partner wake-up state the PHY sends auto-negotiation pulse bursts, switching between media pair A and media pair B, so that a sleeping link partner notices the cable.

All timing is measured in ticks of a clock-enable strobe, for example one tick per millisecond. Once the link is lost, the block waits for a time-out before it enters low power. A two-bit control field selects that time-out from four multiples of a base unit. The block leaves low power as soon as signal energy appears on the media. After a fixed dwell in low power it starts a fixed-length wake-up phase and then returns to low power. A feature-enable input can switch the whole mechanism off.

Top module: `esave_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, state_o is 0, and lowpwr_en, burst_req and pair_b are all 0.
- R2: state_o encodes the state as 0 for normal, 1 for low power and 2 for partner wake-up. lowpwr_en is 1 exactly in state 1, and burst_req is 1 exactly in state 2.
- R3: In the normal state with feat_en high, consecutive ticks with link_up low are counted. When the count reaches (tmo_sel + 1) × UNIT_TICKS, the block enters low power on that tick's clock edge. tmo_sel 0, 1, 2 and 3 therefore give 1, 2, 3 and 4 units. If tmo_sel is lowered below the count already reached, the transition happens on the next tick.
- R4: A cycle with link_up high in the normal state clears the link-loss count, so the block stays in the normal state and a later loss needs the full time-out again.
- R5: In low power, energy_det high moves the block to the normal state on the next clock edge. This takes precedence over the dwell expiry.
- R6: After SLEEP_TICKS ticks in low power without energy, the block enters the wake-up state. The wake-up state is entered only from low power.
- R7: The wake-up state lasts exactly WAKE_TICKS ticks and then returns to low power. energy_det has no effect during this state.
- R8: pair_b is 0 (pair A) when wake-up starts. It toggles after every BURST_TICKS ticks spent in wake-up, and it is 0 whenever the block is not in wake-up.
- R9: feat_en low moves the block to the normal state on the next edge and clears all elapsed counts. While feat_en stays low the block remains in the normal state.
- R10: Without a tick, no time-out, dwell or wake-up count advances, and no timed transition occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_en | input | 1 | Enables the power-saving mechanism |
| energy_det | input | 1 | Signal energy seen on the media |
| link_up | input | 1 | Link status from auto-negotiation |
| tick | input | 1 | Time-base clock enable |
| tmo_sel | input | 2 | Link-loss time-out select |
| burst_req | output | 1 | Request to send pulse bursts |
| pair_b | output | 1 | Burst pair: 0 = pair A, 1 = pair B |
| lowpwr_en | output | 1 | Low-power enable for the analog section |
| state_o | output | 2 | Current state code |

## Verification
A wrong state shows up at once on state_o, lowpwr_en and burst_req, because all three are decoded from the state register in the same cycle. A counter that drifts shows up as a transition that comes one or more ticks too early or too late. The bench finds it by comparing every cycle against a tick-counting reference model. A wrong pair phase shows on pair_b at the first burst boundary inside wake-up. A wrong time-out select shows as a link-loss delay that is off by whole units.

// File: rtl/esave_pkg.sv
package esave_pkg;

  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAKE = 2'd2
  } es_state_t;

  function automatic int tmo_limit(input logic [1:0] sel, input int unit);
    return (int'(sel) + 1) * unit;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int cnt_width(input int maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/esave_tick_cnt.sv
module esave_tick_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q >= (limit - CW'(1)));
  assign hit    = tick && !clr && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (tick)   cnt_q <= at_end ? '0 : cnt_q + CW'(1);
  end

  // R10: a count only moves on a tick
  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/esave_pair_alt.sv
module esave_pair_alt #(
  parameter int BURST_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  output logic pair_b
);
  import esave_pkg::*;
  localparam int BW = cnt_width(BURST_TICKS);

  logic burst_edge;
  logic pair_q;

  esave_tick_cnt #(.CW(BW)) u_burst_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!active),
    .tick  (tick),
    .limit (BW'(BURST_TICKS)),
    .hit   (burst_edge)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pair_q <= 1'b0;
    else if (!active)    pair_q <= 1'b0;
    else if (burst_edge) pair_q <= !pair_q;
  end

  assign pair_b = active && pair_q;

  p_pair_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !pair_b);

  p_pair_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && burst_edge) |=> (active != pair_b) || !active || (pair_q != $past(pair_q)));

endmodule

// File: rtl/esave_ctrl.sv
module esave_ctrl #(
  parameter int UNIT_TICKS  = 1000,
  parameter int SLEEP_TICKS = 2000,
  parameter int WAKE_TICKS  = 2000,
  parameter int BURST_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       feat_en,
  input  logic       energy_det,
  input  logic       link_up,
  input  logic       tick,
  input  logic [1:0] tmo_sel,
  output logic       burst_req,
  output logic       pair_b,
  output logic       lowpwr_en,
  output logic [1:0] state_o
);
  import esave_pkg::*;

  localparam int MAXL = max3(4 * UNIT_TICKS, SLEEP_TICKS, WAKE_TICKS);
  localparam int CW   = cnt_width(MAXL);

  es_state_t st_q, st_d;

  logic tmo_clr, dwell_clr, wake_clr;
  logic tmo_hit, dwell_hit, wake_hit;
  logic go_low_tmo, go_norm_energy, go_wake, go_back_low;
  logic [CW-1:0] tmo_lim;

  assign tmo_lim   = CW'(tmo_limit(tmo_sel, UNIT_TICKS));
  assign tmo_clr   = (st_q != ST_NORM) || link_up || !feat_en;
  assign dwell_clr = (st_q != ST_LOW);
  assign wake_clr  = (st_q != ST_WAKE);

  esave_tick_cnt #(.CW(CW)) u_tmo_cnt (
    .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .tick(tick),
    .limit(tmo_lim), .hit(tmo_hit)
  );

  esave_tick_cnt #(.CW(CW)) u_dwell_cnt (
    .clk(clk), .rst_n(rst_n), .clr(dwell_clr), .tick(tick),
    .limit(CW'(SLEEP_TICKS)), .hit(dwell_hit)
  );

  esave_tick_cnt #(.CW(CW)) u_wake_cnt (
    .clk(clk), .rst_n(rst_n), .clr(wake_clr), .tick(tick),
    .limit(CW'(WAKE_TICKS)), .hit(wake_hit)
  );

  esave_pair_alt #(.BURST_TICKS(BURST_TICKS)) u_pair (
    .clk(clk), .rst_n(rst_n), .active(st_q == ST_WAKE), .tick(tick),
    .pair_b(pair_b)
  );

  assign go_low_tmo     = feat_en && (st_q == ST_NORM) && tmo_hit;
  assign go_norm_energy = feat_en && (st_q == ST_LOW) && energy_det;
  assign go_wake        = feat_en && (st_q == ST_LOW) && !energy_det && dwell_hit;
  assign go_back_low    = feat_en && (st_q == ST_WAKE) && wake_hit;

  always_comb begin
    st_d = st_q;
    if (!feat_en)            st_d = ST_NORM;
    else if (go_low_tmo)     st_d = ST_LOW;
    else if (go_norm_energy) st_d = ST_NORM;
    else if (go_wake)        st_d = ST_WAKE;
    else if (go_back_low)    st_d = ST_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_NORM;
    else        st_q <= st_d;
  end

  assign state_o   = st_q;
  assign lowpwr_en = (st_q == ST_LOW);
  assign burst_req = (st_q == ST_WAKE);

  p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(lowpwr_en && burst_req));
  p_link_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && link_up) |=> state_o == 2'd0);
  p_energy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lowpwr_en && feat_en && energy_det) |=> state_o == 2'd0);
  p_wake_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0) |=> !burst_req);
  p_feat_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_en |=> (state_o == 2'd0));
  p_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && feat_en && !(lowpwr_en && energy_det)) |=> $stable(state_o));

endmodule

// File: tb/test_esave_ctrl.sv
`timescale 1ns/1ps
module test_esave_ctrl;
  localparam int UNIT  = 6;
  localparam int SLEEP = 10;
  localparam int WAKE  = 24;
  localparam int BURST = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic feat_en = 1'b1, energy_det = 1'b0, link_up = 1'b1, tick = 1'b1;
  logic [1:0] tmo_sel = 2'd0;
  logic burst_req, pair_b, lowpwr_en;
  logic [1:0] state_o;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  esave_ctrl #(.UNIT_TICKS(UNIT), .SLEEP_TICKS(SLEEP), .WAKE_TICKS(WAKE),
               .BURST_TICKS(BURST)) i_esave_ctrl (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .energy_det(energy_det),
    .link_up(link_up), .tick(tick), .tmo_sel(tmo_sel), .burst_req(burst_req),
    .pair_b(pair_b), .lowpwr_en(lowpwr_en), .state_o(state_o));

  function automatic int lim_of(input logic [1:0] s);
    return UNIT + int'(s) * UNIT;
  endfunction
  function automatic bit phase_of(input int n);
    return ((n / BURST) % 2) == 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: 0 normal, 1 low, 2 wake; n = ticks counted in current phase
  int m_st = 0, m_n = 0;
  always @(posedge clk) begin
    if (!rst_n) begin m_st <= 0; m_n <= 0; end
    else if (!feat_en) begin m_st <= 0; m_n <= 0; end
    else case (m_st)
      0: if (link_up) m_n <= 0;
         else if (tick) begin
           if (m_n + 1 >= lim_of(tmo_sel)) begin m_st <= 1; m_n <= 0; end
           else m_n <= m_n + 1;
         end
      1: if (energy_det) begin m_st <= 0; m_n <= 0; end
         else if (tick) begin
           if (m_n + 1 >= SLEEP) begin m_st <= 2; m_n <= 0; end
           else m_n <= m_n + 1;
         end
      default: if (tick) begin
           if (m_n + 1 >= WAKE) begin m_st <= 1; m_n <= 0; end
           else m_n <= m_n + 1;
         end
    endcase
  end

  always @(negedge clk) if (cmp_on && rst_n) begin
    check(int'(state_o) == m_st, "R2/R3/R5/R6/R7 state", state_o, m_st);
    check(lowpwr_en == (m_st == 1), "R2 lowpwr_en", lowpwr_en, m_st == 1);
    check(burst_req == (m_st == 2), "R7 burst_req", burst_req, m_st == 2);
    check(pair_b == ((m_st == 2) && phase_of(m_n)), "R8 pair_b", pair_b,
          (m_st == 2) && phase_of(m_n));
  end

  task automatic count_until_low(input int exp, input string req);
    int k = 0;
    while (k < 300) begin
      @(negedge clk); k++;
      if (lowpwr_en) break;
    end
    check(k == exp, req, k, exp);
  endtask

  task automatic back_to_normal();
    @(negedge clk) feat_en = 1'b0;
    @(negedge clk) feat_en = 1'b1;
    check(state_o == 2'd0, "R9 feat_en off", state_o, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(state_o == 2'd0 && !lowpwr_en && !burst_req && !pair_b, "R1 in reset",
          {state_o, lowpwr_en, burst_req, pair_b}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(state_o == 2'd0 && !lowpwr_en && !burst_req, "R1 after reset", state_o, 0);
    cmp_on = 1'b1;

    // R3: each select value, tick every cycle
    for (int s = 0; s < 4; s++) begin
      tmo_sel = 2'(s); link_up = 1'b1;
      @(negedge clk) link_up = 1'b0;
      count_until_low(lim_of(2'(s)), "R3 timeout length");
      link_up = 1'b1;
      back_to_normal();
    end

    // R4: link returns just before expiry, full time-out needed again
    tmo_sel = 2'd1;
    @(negedge clk) link_up = 1'b0;
    repeat (lim_of(2'd1) - 1) @(negedge clk);
    link_up = 1'b1;
    @(negedge clk);
    check(state_o == 2'd0, "R4 cancel", state_o, 0);
    link_up = 1'b0;
    count_until_low(lim_of(2'd1), "R4 full restart");

    // R5: energy wakes to normal
    @(negedge clk) energy_det = 1'b1;
    @(negedge clk) energy_det = 1'b0;
    check(state_o == 2'd0, "R5 energy exit", state_o, 0);

    // R10: no ticks, link down, no transition
    link_up = 1'b1; tmo_sel = 2'd0;
    @(negedge clk) begin link_up = 1'b0; tick = 1'b0; end
    repeat (40) @(negedge clk);
    check(state_o == 2'd0, "R10 no tick hold", state_o, 0);
    tick = 1'b1;
    count_until_low(UNIT, "R10 resumes with ticks");

    // R6/R7/R8: dwell, wake length, pair phases (energy ignored in wake)
    begin
      int k = 0;
      while (!burst_req && k < 300) begin @(negedge clk); k++; end
      check(k == SLEEP, "R6 dwell length", k, SLEEP);
      check(pair_b == 1'b0, "R8 starts on pair A", pair_b, 0);
      energy_det = 1'b1;
      k = 1;
      while (burst_req && k < 300) begin
        @(negedge clk);
        if (burst_req) check(pair_b == phase_of(k), "R8 pair phase", pair_b, phase_of(k));
        if (burst_req) k++;
      end
      check(k == WAKE, "R7 wake length", k, WAKE);
      energy_det = 1'b0;
      @(negedge clk);
    end
    back_to_normal();

    // constrained random
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      tick = ($urandom % 4) != 0;
      if ($urandom % 40 == 0) link_up = !link_up;
      energy_det = ($urandom % 60) == 0;
      feat_en = ($urandom % 400) != 0;
      if ($urandom % 150 == 0) tmo_sel = 2'($urandom);
    end
    @(negedge clk);
    finish_run();
  end
endmodule